// File: doc/BRIEF.md
# Fractional-Divide UART Bit Timer

This block times the bits of a serial link from whatever clock the chip happens to have. It is meant for cases where that clock is not an integer multiple of the wanted baud rate. The wanted division factor, input clock over baud rate, is split into two parts:

- An integer prescaler gives the base number of input clocks in each bit.
- An 8-entry stretch pattern lengthens chosen bits by one extra input clock.

Over one pass through the pattern, the mean bit length comes close to the fractional factor. For example, a 15 MHz clock with a prescaler of 65 and one stretched bit in eight gives a mean of 65.125 clocks per bit. That is within about 0.1 % of 230400 baud.

The shift logic on the transmit or receive side of a UART uses the strobe to move one bit. It can also read the pattern index that sets the length of the current bit. A frame begins when the enable rises. While the enable is low the timer rests at the start of bit 0. Configuration written while the timer runs is picked up only at a bit boundary, so no bit is ever cut short or made longer mid-way.

Top module: `baudmod_gen`

## Requirements
- R1: While reset is high, and in the cycle after reset is released, `bit_tick` is 0 and `bit_idx` is 0.
- R2: A bit whose stretch-pattern entry is 0 lasts exactly the latched prescaler value in input clocks.
- R3: A bit whose stretch-pattern entry is 1 lasts the latched prescaler value plus one input clock. Bit n of `stretch_pat` belongs to pattern index n.
- R4: `bit_tick` is high for exactly one input clock, the last clock of each bit, and is never high on two clocks in a row.
- R5: `bit_idx` holds steady during a bit and advances by one in the clock after each `bit_tick`. It wraps from 7 to 0.
- R6: While `en` is low, `bit_tick` stays 0 and `bit_idx` returns to 0 (one clock after `en` falls). When `en` rises again, a full bit 0 starts, with its length taken from the inputs present during the idle period.
- R7: A prescaler value of 0, 1 or 2 acts as 3.
- R8: `presc` and `stretch_pat` are captured only while idle or in the clock of `bit_tick`. A change in the middle of a bit does not alter that bit's length.
- R9: With a fixed setup, eight bits starting at `en` rising take 8·presc + popcount(stretch_pat) input clocks in total. With a prescaler of 65 and a pattern of 8'h10 that is 521 clocks, so the eighth strobe comes 520 clocks after the first enabled clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock that is divided down |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; a rising edge starts a frame at bit 0 |
| presc | input | 16 | Integer clocks per bit; values below 3 act as 3 |
| stretch_pat | input | 8 | Per-bit stretch flags, bit n for pattern index n |
| bit_tick | output | 1 | One-clock strobe on the last clock of each bit |
| bit_idx | output | 3 | Pattern index of the bit in progress |

## Verification
Two events can fall on the same clock:

- a change of `presc` or `stretch_pat` on the clock that `bit_tick` is high;
- the fall of `en` on a strobe clock, or during a stretched bit.

The bench causes both, with random changes at random times and with directed changes timed against a strobe. For each case it checks two things. The bit that is ending must keep its old length. The next bit must use the new value, or, after an idle gap, must start as a fresh bit 0.

// File: rtl/baudmod_pkg.sv
package baudmod_pkg;

    // Default widths of the configuration inputs
    localparam int unsigned PRESC_W_DEF = 16;
    localparam int unsigned PAT_W_DEF   = 8;

    // Shortest bit the timer produces, in input clocks
    localparam int unsigned MIN_DIV     = 3;

    // Raise a too-small prescaler to the shortest legal bit
    function automatic int unsigned clamp_div(input int unsigned raw);
        return (raw < MIN_DIV) ? MIN_DIV : raw;
    endfunction

    // Width of a pattern index for a pattern of the given length
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/bm_cfg_shadow.sv
module bm_cfg_shadow #(
    parameter int unsigned PRESC_W = baudmod_pkg::PRESC_W_DEF,
    parameter int unsigned PAT_W   = baudmod_pkg::PAT_W_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [PRESC_W-1:0] presc_in,
    input  logic [PAT_W-1:0]   pat_in,
    output logic [PRESC_W-1:0] presc_q,
    output logic [PAT_W-1:0]   pat_q
);
    import baudmod_pkg::*;

    logic [PRESC_W-1:0] presc_clamped;

    always_comb begin
        presc_clamped = PRESC_W'(clamp_div(32'(presc_in)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            presc_q <= PRESC_W'(MIN_DIV);
            pat_q   <= '0;
        end else if (load) begin
            presc_q <= presc_clamped;
            pat_q   <= pat_in;
        end
    end

endmodule

// File: rtl/bm_pattern_ptr.sv
module bm_pattern_ptr #(
    parameter int unsigned PAT_W = baudmod_pkg::PAT_W_DEF,
    localparam int unsigned IDX_W = baudmod_pkg::idx_width(PAT_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic [PAT_W-1:0] pat_q,
    output logic [IDX_W-1:0] idx,
    output logic             stretch
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(PAT_W - 1);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            idx <= '0;
        end else if (tick) begin
            idx <= (idx == LAST) ? '0 : idx + IDX_W'(1);
        end
    end

    always_comb begin
        stretch = pat_q[idx];
    end

endmodule

// File: rtl/bm_period_counter.sv
module bm_period_counter #(
    parameter int unsigned PRESC_W = baudmod_pkg::PRESC_W_DEF,
    localparam int unsigned CNT_W = PRESC_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [PRESC_W-1:0] presc_q,
    input  logic               stretch,
    output logic               tick
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_cnt;

    always_comb begin
        last_cnt = {1'b0, presc_q} + CNT_W'(stretch) - CNT_W'(1);
        tick     = en && (cnt == last_cnt);
    end

    always_ff @(posedge clk) begin
        if (rst || !en || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/baudmod_gen.sv
module baudmod_gen #(
    parameter int unsigned PRESC_W = baudmod_pkg::PRESC_W_DEF,
    parameter int unsigned PAT_W   = baudmod_pkg::PAT_W_DEF,
    localparam int unsigned IDX_W  = baudmod_pkg::idx_width(PAT_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [PRESC_W-1:0] presc,
    input  logic [PAT_W-1:0]   stretch_pat,
    output logic               bit_tick,
    output logic [IDX_W-1:0]   bit_idx
);
    logic [PRESC_W-1:0] presc_q;
    logic [PAT_W-1:0]   pat_q;
    logic               stretch;
    logic               cfg_load;

    // Settings are captured while idle or at the boundary between two bits
    always_comb begin
        cfg_load = !en || bit_tick;
    end

    bm_cfg_shadow #(.PRESC_W(PRESC_W), .PAT_W(PAT_W)) u_shadow (
        .clk      (clk),
        .rst      (rst),
        .load     (cfg_load),
        .presc_in (presc),
        .pat_in   (stretch_pat),
        .presc_q  (presc_q),
        .pat_q    (pat_q)
    );

    bm_pattern_ptr #(.PAT_W(PAT_W)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .tick    (bit_tick),
        .pat_q   (pat_q),
        .idx     (bit_idx),
        .stretch (stretch)
    );

    bm_period_counter #(.PRESC_W(PRESC_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .presc_q (presc_q),
        .stretch (stretch),
        .tick    (bit_tick)
    );

endmodule

// File: rtl/baudmod_gen_chk.sv
module baudmod_gen_chk #(
    parameter int unsigned PAT_W = baudmod_pkg::PAT_W_DEF,
    localparam int unsigned IDX_W = baudmod_pkg::idx_width(PAT_W)
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             bit_tick,
    input logic [IDX_W-1:0] bit_idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(PAT_W - 1);

    // Clocks that have gone by in the current bit before this one
    logic [31:0] run_len;

    always_ff @(posedge clk) begin
        if (rst || !en || bit_tick) begin
            run_len <= '0;
        end else begin
            run_len <= run_len + 32'd1;
        end
    end

    // R4: the strobe lasts a single clock
    a_r4_single_strobe: assert property (@(posedge clk) disable iff (rst)
        bit_tick |=> !bit_tick);

    // R5: index unchanged inside a bit
    a_r5_idx_hold: assert property (@(posedge clk) disable iff (rst)
        (en && !bit_tick) |=> $stable(bit_idx));

    // R5: index steps after a strobe and wraps at the end of the pattern
    a_r5_idx_step: assert property (@(posedge clk) disable iff (rst)
        (en && bit_tick) |=>
            (bit_idx == (($past(bit_idx) == LAST) ? '0 : $past(bit_idx) + IDX_W'(1))));

    // R6: idle clears the index
    a_r6_idle_index: assert property (@(posedge clk) disable iff (rst)
        !en |=> (bit_idx == '0));

    // R7: no bit is shorter than three clocks
    a_r7_min_length: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> (run_len >= 32'd2));

endmodule

bind baudmod_gen baudmod_gen_chk #(.PAT_W(PAT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .bit_tick (bit_tick),
    .bit_idx  (bit_idx)
);

// File: tb/test_baudmod_gen.sv
module test_baudmod_gen;

    logic        clk = 1'b0;
    logic        rst;
    logic        en;
    logic [15:0] presc;
    logic [7:0]  pat;
    logic        bit_tick;
    logic [2:0]  bit_idx;

    always #10 clk = ~clk;

    baudmod_gen i_baudmod_gen (
        .clk         (clk),
        .rst         (rst),
        .en          (en),
        .presc       (presc),
        .stretch_pat (pat),
        .bit_tick    (bit_tick),
        .bit_idx     (bit_idx)
    );

    int    checks = 0;
    int    fails  = 0;
    string tag    = "R1";

    // Expected state, advanced from the requirements
    int       m_cnt  = 0;
    int       m_idx  = 0;
    int       m_div  = 3;
    logic [7:0] m_pat = '0;
    bit       m_tick = 0;
    bit       prev_tick = 0;
    int       tick_seen = 0;
    bit       done = 0;

    // R2, R3, R7: length of bit i
    function automatic int bit_len(input int d, input logic [7:0] p, input int i);
        return ((d < 3) ? 3 : d) + int'(p[i]);
    endfunction

    task automatic cycle();
        @(negedge clk);
        if (rst) begin
            m_cnt = 0; m_idx = 0; m_div = 3; m_pat = '0;
        end else if (!en) begin
            m_cnt = 0; m_idx = 0; m_div = int'(presc); m_pat = pat;
        end else if (m_tick) begin
            m_cnt = 0; m_idx = (m_idx + 1) % 8; m_div = int'(presc); m_pat = pat;
        end else begin
            m_cnt++;
        end
        m_tick = en && (m_cnt == bit_len(m_div, m_pat, m_idx) - 1);
        checks++;
        if (bit_tick !== m_tick || bit_idx !== 3'(m_idx)) begin
            fails++;
            $display("FAIL %s: tick=%0b idx=%0d expected tick=%0b idx=%0d",
                     tag, bit_tick, bit_idx, m_tick, m_idx);
        end
        // R4: never two strobes in a row
        checks++;
        if (prev_tick && bit_tick === 1'b1) begin
            fails++;
            $display("FAIL R4: tick=1 on consecutive clocks expected tick=0");
        end
        prev_tick = (bit_tick === 1'b1);
        if (bit_tick === 1'b1) tick_seen++;
    endtask

    task automatic run(input int n);
        for (int k = 0; k < n; k++) cycle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4051));
        rst = 1'b1; en = 1'b0; presc = 16'd10; pat = 8'h00;
        tag = "R1"; run(3);
        rst = 1'b0; run(2);

        tag = "R2"; presc = 16'd6; pat = 8'h00; en = 1'b1; run(60);
        en = 1'b0; run(1);
        tag = "R3"; presc = 16'd5; pat = 8'hFF; en = 1'b1; run(60);
        en = 1'b0; run(1);
        tag = "R5"; presc = 16'd4; pat = 8'hA5; en = 1'b1; run(120);

        tag = "R7";
        for (int v = 0; v < 3; v++) begin
            en = 1'b0; presc = 16'(v); pat = 8'h00; run(2);
            en = 1'b1; run(30);
        end

        // R8: change the settings in the middle of a bit, and on a strobe
        tag = "R8"; en = 1'b0; presc = 16'd20; pat = 8'h00; run(1);
        en = 1'b1; run(5); presc = 16'd4; pat = 8'hFF; run(40);
        while (bit_tick !== 1'b1) cycle();
        presc = 16'd7; pat = 8'h00; run(40);

        // R6: drop enable during a stretched bit and again on a strobe
        tag = "R6"; pat = 8'hFF; run(3); en = 1'b0; presc = 16'd9; run(5);
        en = 1'b1; run(30);
        while (bit_tick !== 1'b1) cycle();
        en = 1'b0; run(3); en = 1'b1; run(30);

        // R9: 15 MHz clock, 230400 baud
        tag = "R9"; en = 1'b0; presc = 16'd65; pat = 8'h10; run(2);
        en = 1'b1; tick_seen = 0;
        begin
            int samples = 0;
            while (tick_seen < 8 && samples < 2000) begin
                cycle(); samples++;
            end
            checks++;
            if (samples != 520) begin
                fails++;
                $display("FAIL R9: eighth strobe at %0d expected 520", samples);
            end
        end

        // Random mix for R2, R3, R4, R5, R6, R7, R8
        tag = "R2,R3,R5,R6,R8 random";
        for (int k = 0; k < 30000; k++) begin
            cycle();
            if ($urandom_range(39) == 0)
                presc = ($urandom_range(3) == 0) ? 16'($urandom_range(40)) : 16'($urandom_range(8));
            if ($urandom_range(39) == 0) pat = 8'($urandom);
            if ($urandom_range(299) == 0) en = ~en;
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule